// File: doc/BRIEF.md
# Tagged History Predictor Stage

This block is one tagged stage of a cascade of branch direction predictors. On the lookup side it takes the word address of the fetched branch, the most recent global branch history and the direction offered by the stage below it. It gives back a single direction. The stage takes over only when it holds a confident entry that has proved its worth. In every other case it passes the lower direction through unchanged.

The table is direct mapped, with `2**IDX_W` entries. Each entry stores a valid flag, a partial tag, a 3-bit saturating direction counter and a useful bit. The training port takes the resolved branch: its address and history, the real outcome, the lower stage's guess and the final direction the whole predictor used. On a hit, training adjusts the counter and may mark the entry useful. On a miss where the final direction was wrong, training claims the entry for the branch, provided that entry is not marked useful. Mispredicts that find the slot taken by a useful entry advance an aging counter. When that counter fills, every useful bit is wiped at once.

Top module: `tagged_hist_stage`

## Requirements
- R1: Hashing works on folds. fold_N(x) is N bits wide; its bit i is the XOR of every bit j of x with j mod N = i. The slot is pcw[IDX_W-1:0] XOR fold_IDX_W(hist). The tag is fold_TAG_W(pcw[PCW_W-1:IDX_W]) XOR rotl1(fold_TAG_W(hist)), where rotl1 rotates left by one bit. A branch trained with one (pcw, hist) pair is therefore found by any other pair that yields the same slot and tag.
- R2: The stage overrides only when three things hold: the slot is valid, its stored tag equals the lookup tag, and its useful bit is set with a strong counter (value 0, 1, 6 or 7). Otherwise `lk_override` is 0 and `lk_taken` equals `lk_lower_taken`. A tag mismatch counts as a miss.
- R3: When the stage overrides, `lk_override` is 1 and `lk_taken` is bit 2 of the counter, so 6 and 7 mean taken and 0 and 1 mean not taken.
- R4: Training that hits sets the useful bit when the counter's bit 2 before the update equals the outcome and `tr_lower_taken` differs from it. In every other case training leaves the bit as it was.
- R5: Training that hits adds one to the counter when the outcome is taken and subtracts one when it is not. The counter saturates at 7 and at 0.
- R6: Training that misses, with `tr_final_taken` different from `tr_taken`, claims the slot if its useful bit is clear. The slot then holds the new tag, counter 4 (taken) or 3 (not taken), and a clear useful bit.
- R7: A mispredicting miss whose slot has its useful bit set leaves that slot unchanged and advances the aging counter by one.
- R8: The event that brings the aging counter to CLR_LIMIT clears every useful bit and returns the counter to 0. The next clear needs another CLR_LIMIT such events.
- R9: After reset every slot is invalid and the aging counter is 0, so no lookup overrides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pcw | input | PCW_W | Word address of the branch being looked up |
| lk_hist | input | HIST_LEN | Global history for the lookup, newest outcome in bit 0 |
| lk_lower_taken | input | 1 | Direction offered by the lower stage |
| lk_taken | output | 1 | Direction passed up the cascade |
| lk_override | output | 1 | High when this stage supplied `lk_taken` |
| tr_valid | input | 1 | A resolved branch is being trained this cycle |
| tr_pcw | input | PCW_W | Word address of the resolved branch |
| tr_hist | input | HIST_LEN | History the branch was predicted with |
| tr_taken | input | 1 | Resolved outcome |
| tr_lower_taken | input | 1 | Lower stage's direction for that branch |
| tr_final_taken | input | 1 | Direction the full predictor used |

## Verification
The bench drives the counter into both saturation limits and then steps back. A design that wrapped from 7 to 0, or from 0 to 7, would still show a strong counter when a correct one has gone weak. Three cases target the useful bit. One entry is trained correctly while the lower stage is also correct; it must reach a strong state yet still not override. A second entry shares a slot with a different tag, and its lookup must fall through. A third is trained under a non-zero history and must then be found from a different address whose hash gives the same slot and tag; a wrong fold would miss it. Allocation is tried against a useful occupant both before and after the aging counter fills. The bench checks that the aging counter restarts from zero and needs a full CLR_LIMIT events for the next clear; a design that forgot to wrap would clear too early or never.

// File: rtl/thp_pkg.sv
package thp_pkg;

    localparam int CTR_W   = 3;
    localparam int CTR_MAX = (1 << CTR_W) - 1;
    localparam int CTR_MID = 1 << (CTR_W - 1);

    typedef logic [CTR_W-1:0] ctr_t;

    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_TRAIN,
        ACT_CLAIM,
        ACT_BLOCKED
    } train_act_e;

    function automatic ctr_t ctr_step(ctr_t c, logic up);
        ctr_t r;
        r = c;
        if (up && c != ctr_t'(CTR_MAX))
            r = c + 1'b1;
        else if (!up && c != '0)
            r = c - 1'b1;
        return r;
    endfunction

    function automatic logic ctr_confident(ctr_t c);
        return (c <= ctr_t'(1)) || (c >= ctr_t'(CTR_MAX - 1));
    endfunction

    function automatic ctr_t ctr_seed(logic up);
        return up ? ctr_t'(CTR_MID) : ctr_t'(CTR_MID - 1);
    endfunction

endpackage

// File: rtl/thp_hash.sv
module thp_hash #(
    parameter int PCW_W    = 30,
    parameter int HIST_LEN = 16,
    parameter int IDX_W    = 6,
    parameter int TAG_W    = 8
) (
    input  logic [PCW_W-1:0]    pcw,
    input  logic [HIST_LEN-1:0] hist,
    output logic [IDX_W-1:0]    slot,
    output logic [TAG_W-1:0]    tag
);
    localparam int HI_W = PCW_W - IDX_W;

    logic [IDX_W-1:0] hist_fold_i;
    logic [TAG_W-1:0] hist_fold_t;
    logic [TAG_W-1:0] pc_fold_t;

    always_comb begin
        hist_fold_i = '0;
        for (int j = 0; j < HIST_LEN; j++)
            hist_fold_i[j % IDX_W] = hist_fold_i[j % IDX_W] ^ hist[j];
    end

    always_comb begin
        hist_fold_t = '0;
        for (int j = 0; j < HIST_LEN; j++)
            hist_fold_t[j % TAG_W] = hist_fold_t[j % TAG_W] ^ hist[j];
    end

    always_comb begin
        pc_fold_t = '0;
        for (int j = 0; j < HI_W; j++)
            pc_fold_t[j % TAG_W] = pc_fold_t[j % TAG_W] ^ pcw[IDX_W + j];
    end

    assign slot = pcw[IDX_W-1:0] ^ hist_fold_i;
    assign tag  = pc_fold_t ^ {hist_fold_t[TAG_W-2:0], hist_fold_t[TAG_W-1]};

endmodule

// File: rtl/thp_aging.sv
module thp_aging #(
    parameter int CLR_LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic blocked,
    output logic wipe
);
    localparam int CW = (CLR_LIMIT > 2) ? $clog2(CLR_LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLR_LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign wipe = blocked && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (wipe)
            cnt_q <= '0;
        else if (blocked)
            cnt_q <= cnt_q + 1'b1;
    end

    assert_age_range_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    assert_age_restart_R8: assert property (@(posedge clk) disable iff (rst)
        wipe |=> cnt_q == '0);

endmodule

// File: rtl/thp_table.sv
module thp_table
    import thp_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_slot,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             lk_lower,
    output logic             lk_taken,
    output logic             lk_override,
    input  logic             tr_valid,
    input  logic [IDX_W-1:0] tr_slot,
    input  logic [TAG_W-1:0] tr_tag,
    input  logic             tr_taken,
    input  logic             tr_lower,
    input  logic             tr_final,
    input  logic             wipe,
    output logic             blocked
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        ctr_t             ctr;
    } entry_t;

    entry_t           ent_q [DEPTH];
    logic [DEPTH-1:0] useful_q;

    entry_t     lk_ent;
    logic       lk_hit;
    entry_t     tr_ent;
    logic       tr_hit;
    logic       tr_miss_wrong;
    logic       mark_useful;
    train_act_e act;

    always_comb begin
        lk_ent      = ent_q[lk_slot];
        lk_hit      = lk_ent.valid && (lk_ent.tag == lk_tag);
        lk_override = lk_hit && useful_q[lk_slot] && ctr_confident(lk_ent.ctr);
        lk_taken    = lk_override ? lk_ent.ctr[CTR_W-1] : lk_lower;
    end

    always_comb begin
        tr_ent        = ent_q[tr_slot];
        tr_hit        = tr_ent.valid && (tr_ent.tag == tr_tag);
        tr_miss_wrong = !tr_hit && (tr_final != tr_taken);
        act           = ACT_IDLE;
        if (tr_valid) begin
            if (tr_hit)
                act = ACT_TRAIN;
            else if (tr_miss_wrong)
                act = useful_q[tr_slot] ? ACT_BLOCKED : ACT_CLAIM;
        end
        mark_useful = (act == ACT_TRAIN)
                   && (tr_ent.ctr[CTR_W-1] == tr_taken)
                   && (tr_lower != tr_taken);
        blocked     = (act == ACT_BLOCKED);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++)
                ent_q[k] <= '0;
        end else begin
            case (act)
                ACT_TRAIN: ent_q[tr_slot].ctr <= ctr_step(tr_ent.ctr, tr_taken);
                ACT_CLAIM: ent_q[tr_slot] <= '{valid: 1'b1, tag: tr_tag,
                                               ctr: ctr_seed(tr_taken)};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            useful_q <= '0;
        else if (wipe)
            useful_q <= '0;
        else if (mark_useful)
            useful_q[tr_slot] <= 1'b1;
    end

    assert_ctr_rise_R5: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_TRAIN && tr_taken && tr_ent.ctr != ctr_t'(CTR_MAX))
        |=> ent_q[$past(tr_slot)].ctr > $past(tr_ent.ctr));

    assert_ctr_top_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_TRAIN && tr_taken && tr_ent.ctr == ctr_t'(CTR_MAX))
        |=> ent_q[$past(tr_slot)].ctr == ctr_t'(CTR_MAX));

    assert_claim_fields_R6: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_CLAIM)
        |=> ent_q[$past(tr_slot)].valid
            && ent_q[$past(tr_slot)].tag == $past(tr_tag)
            && !useful_q[$past(tr_slot)]);

    assert_blocked_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_BLOCKED)
        |=> ent_q[$past(tr_slot)] == $past(tr_ent));

    assert_wipe_all_R8: assert property (@(posedge clk) disable iff (rst)
        wipe |=> useful_q == '0);

endmodule

// File: rtl/tagged_hist_stage.sv
module tagged_hist_stage #(
    parameter int PCW_W     = 30,
    parameter int HIST_LEN  = 16,
    parameter int IDX_W     = 6,
    parameter int TAG_W     = 8,
    parameter int CLR_LIMIT = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PCW_W-1:0]    lk_pcw,
    input  logic [HIST_LEN-1:0] lk_hist,
    input  logic                lk_lower_taken,
    output logic                lk_taken,
    output logic                lk_override,
    input  logic                tr_valid,
    input  logic [PCW_W-1:0]    tr_pcw,
    input  logic [HIST_LEN-1:0] tr_hist,
    input  logic                tr_taken,
    input  logic                tr_lower_taken,
    input  logic                tr_final_taken
);
    logic [IDX_W-1:0] lk_slot, tr_slot;
    logic [TAG_W-1:0] lk_tag,  tr_tag;
    logic             blocked, wipe;

    thp_hash #(.PCW_W(PCW_W), .HIST_LEN(HIST_LEN), .IDX_W(IDX_W), .TAG_W(TAG_W))
    u_hash_lk (.pcw(lk_pcw), .hist(lk_hist), .slot(lk_slot), .tag(lk_tag));

    thp_hash #(.PCW_W(PCW_W), .HIST_LEN(HIST_LEN), .IDX_W(IDX_W), .TAG_W(TAG_W))
    u_hash_tr (.pcw(tr_pcw), .hist(tr_hist), .slot(tr_slot), .tag(tr_tag));

    thp_table #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
        .clk         (clk),
        .rst         (rst),
        .lk_slot     (lk_slot),
        .lk_tag      (lk_tag),
        .lk_lower    (lk_lower_taken),
        .lk_taken    (lk_taken),
        .lk_override (lk_override),
        .tr_valid    (tr_valid),
        .tr_slot     (tr_slot),
        .tr_tag      (tr_tag),
        .tr_taken    (tr_taken),
        .tr_lower    (tr_lower_taken),
        .tr_final    (tr_final_taken),
        .wipe        (wipe),
        .blocked     (blocked)
    );

    thp_aging #(.CLR_LIMIT(CLR_LIMIT)) u_aging (
        .clk     (clk),
        .rst     (rst),
        .blocked (blocked),
        .wipe    (wipe)
    );

    assert_pass_through_R2: assert property (@(posedge clk) disable iff (rst)
        !lk_override |-> lk_taken == lk_lower_taken);

endmodule

// File: tb/tagged_hist_stage_bench.sv
module tagged_hist_stage_bench;
    localparam int PCW_W = 30, HIST_LEN = 16, IDX_W = 6, TAG_W = 8, CLR_LIMIT = 8;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [PCW_W-1:0]    lk_pcw = '0;
    logic [HIST_LEN-1:0] lk_hist = '0;
    logic                lk_lower_taken = 1'b0;
    logic                lk_taken, lk_override;
    logic                tr_valid = 1'b0;
    logic [PCW_W-1:0]    tr_pcw = '0;
    logic [HIST_LEN-1:0] tr_hist = '0;
    logic                tr_taken = 1'b0, tr_lower_taken = 1'b0, tr_final_taken = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    tagged_hist_stage u_tagged_hist_stage (
        .clk(clk), .rst(rst),
        .lk_pcw(lk_pcw), .lk_hist(lk_hist), .lk_lower_taken(lk_lower_taken),
        .lk_taken(lk_taken), .lk_override(lk_override),
        .tr_valid(tr_valid), .tr_pcw(tr_pcw), .tr_hist(tr_hist),
        .tr_taken(tr_taken), .tr_lower_taken(tr_lower_taken),
        .tr_final_taken(tr_final_taken)
    );

    always #10 clk = ~clk;

    // Addresses used with zero history: slot = pcw[5:0], tag = pcw[13:6]
    localparam logic [PCW_W-1:0] PC_A = 30'h040;  // slot 0 tag 1
    localparam logic [PCW_W-1:0] PC_D = 30'h000;  // slot 0 tag 0
    localparam logic [PCW_W-1:0] PC_C = 30'h081;  // slot 1 tag 2
    localparam logic [PCW_W-1:0] PC_F = 30'h0C5;  // slot 5 tag 3
    localparam logic [PCW_W-1:0] PC_G = 30'h105;  // slot 5 tag 4
    localparam logic [HIST_LEN-1:0] HIST_H = 16'h0003;

    // R1 hashing written from the requirement text
    function automatic logic [PCW_W-1:0] alias_pcw(logic [PCW_W-1:0] pcw, logic [HIST_LEN-1:0] h);
        logic [IDX_W-1:0] s;
        logic [TAG_W-1:0] ht, pt, t;
        s = pcw[IDX_W-1:0]; ht = '0; pt = '0;
        for (int j = 0; j < HIST_LEN; j++) s[j % IDX_W] ^= h[j];
        for (int j = 0; j < HIST_LEN; j++) ht[j % TAG_W] ^= h[j];
        for (int j = 0; j < PCW_W - IDX_W; j++) pt[j % TAG_W] ^= pcw[IDX_W + j];
        t = pt ^ {ht[TAG_W-2:0], ht[TAG_W-1]};
        return {{(PCW_W-IDX_W-TAG_W){1'b0}}, t, s};
    endfunction

    task automatic check(string req, logic act, logic exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic look(string req, logic [PCW_W-1:0] pcw, logic [HIST_LEN-1:0] h,
                        logic lower, logic exp_taken, logic exp_ovr);
        lk_pcw = pcw; lk_hist = h; lk_lower_taken = lower;
        #1;
        check(req, lk_override, exp_ovr, "override");
        check(req, lk_taken, exp_taken, "direction");
    endtask

    task automatic train(logic [PCW_W-1:0] pcw, logic [HIST_LEN-1:0] h,
                         logic t, logic lower, logic fin);
        @(negedge clk);
        tr_pcw = pcw; tr_hist = h; tr_taken = t;
        tr_lower_taken = lower; tr_final_taken = fin; tr_valid = 1'b1;
        @(negedge clk);
        tr_valid = 1'b0;
    endtask

    task automatic t_reset;  // R9
        look("R9", PC_A, '0, 1'b0, 1'b0, 1'b0);
        look("R9", PC_A, '0, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_claim_and_learn;  // R6 R4 R2 R3
        train(PC_A, '0, 1'b1, 1'b0, 1'b0);           // claim, counter 4
        look("R6", PC_A, '0, 1'b0, 1'b0, 1'b0);
        look("R6", PC_A, '0, 1'b1, 1'b1, 1'b0);
        train(PC_A, '0, 1'b1, 1'b0, 1'b0);           // 5, useful
        look("R2", PC_A, '0, 1'b0, 1'b0, 1'b0);       // weak: no override
        train(PC_A, '0, 1'b1, 1'b0, 1'b0);           // 6
        look("R3", PC_A, '0, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_tag_miss;  // R2
        look("R2", PC_D, '0, 1'b0, 1'b0, 1'b0);
        look("R2", PC_D, '0, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_saturation;  // R5 R3
        for (int k = 0; k < 3; k++) train(PC_A, '0, 1'b1, 1'b0, 1'b0);  // stays 7
        for (int k = 0; k < 2; k++) train(PC_A, '0, 1'b0, 1'b0, 1'b0);  // 5
        look("R5", PC_A, '0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) train(PC_A, '0, 1'b0, 1'b0, 1'b0);  // 1
        look("R3", PC_A, '0, 1'b1, 1'b0, 1'b1);
        for (int k = 0; k < 2; k++) train(PC_A, '0, 1'b0, 1'b0, 1'b0);  // stays 0
        for (int k = 0; k < 2; k++) train(PC_A, '0, 1'b1, 1'b0, 1'b0);  // 2
        look("R5", PC_A, '0, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_useful_rule;  // R4
        train(PC_C, '0, 1'b1, 1'b0, 1'b0);           // claim 4
        train(PC_C, '0, 1'b1, 1'b1, 1'b1);           // 5, lower right
        train(PC_C, '0, 1'b1, 1'b1, 1'b1);           // 6, lower right
        look("R4", PC_C, '0, 1'b0, 1'b0, 1'b0);
        train(PC_C, '0, 1'b1, 1'b0, 1'b0);           // 7, now useful
        look("R4", PC_C, '0, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_hash;  // R1
        logic [PCW_W-1:0] twin;
        twin = alias_pcw(PC_A, HIST_H);
        train(PC_A, HIST_H, 1'b1, 1'b0, 1'b0);
        train(PC_A, HIST_H, 1'b1, 1'b0, 1'b0);
        train(PC_A, HIST_H, 1'b1, 1'b0, 1'b0);       // 6, useful
        look("R1", PC_A, HIST_H, 1'b0, 1'b1, 1'b1);
        look("R1", twin, '0, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_aging;  // R7 R8 R6
        train(PC_F, '0, 1'b1, 1'b0, 1'b0);
        train(PC_F, '0, 1'b1, 1'b0, 1'b0);
        train(PC_F, '0, 1'b1, 1'b0, 1'b0);           // F strong, useful
        for (int k = 0; k < CLR_LIMIT - 1; k++) train(PC_G, '0, 1'b0, 1'b1, 1'b1);
        look("R7", PC_F, '0, 1'b0, 1'b1, 1'b1);
        look("R7", PC_G, '0, 1'b1, 1'b1, 1'b0);
        train(PC_G, '0, 1'b0, 1'b1, 1'b1);           // limit reached
        look("R8", PC_F, '0, 1'b0, 1'b0, 1'b0);
        look("R8", alias_pcw(PC_A, HIST_H), '0, 1'b0, 1'b0, 1'b0);
        train(PC_G, '0, 1'b1, 1'b0, 1'b0);           // claims slot 5
        train(PC_G, '0, 1'b1, 1'b0, 1'b0);
        train(PC_G, '0, 1'b1, 1'b0, 1'b0);           // G strong, useful
        look("R6", PC_G, '0, 1'b0, 1'b1, 1'b1);
        look("R6", PC_F, '0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < CLR_LIMIT - 1; k++) train(PC_F, '0, 1'b0, 1'b1, 1'b1);
        look("R8", PC_G, '0, 1'b0, 1'b1, 1'b1);       // counter restarted at 0
        train(PC_F, '0, 1'b0, 1'b1, 1'b1);
        look("R8", PC_G, '0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_claim_and_learn();
        t_tag_miss();
        t_saturation();
        t_useful_rule();
        t_hash();
        t_aging();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule